// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Access

This peripheral guards against a stalled processor. A down-counter advances on each cycle in which a watchdog tick-enable input is high. When the counter runs out for the first time, it sets an interrupt flag and starts again from the reload value. This gives software one full period to service the interrupt. If the flag is still set when the counter runs out a second time, the block raises a sticky reset request and the counter freezes.

Software reaches the block through an APB slave port with word-aligned registers:

| Offset | Register |
|--------|----------|
| 0x000 | reload value |
| 0x004 | live count, read-only |
| 0x008 | control |
| 0x00C | interrupt clear, write-only |
| 0x010 | raw interrupt status |
| 0x014 | masked interrupt status |
| 0xC00 | write-lock key |
| 0xF00 | test-mode enable |
| 0xF04 | test-mode output values, write-only |
| 0xFD0–0xFFC | identification words, read-only |

A write-lock that only a fixed key can open protects the configuration. A test mode lets a board-level test drive both output pins directly. Producing the system reset itself, beyond the request pin, is left to the surrounding chip.

Top module: `wdt2s_top`

## Requirements
- R1: After reset, the registers read as follows. The reload value is 0xFFFFFFFF and the live count is 0xFFFFFFFF. Control, raw status, lock, test enable and test outputs are all 0. Both output pins are low.
- R2: Control bit 0 is the interrupt enable and bit 1 is the reset enable. All other control bits are discarded and read back as zero.
- R3: Each cycle with `tickEn` high decrements a non-zero count by one. A tick that arrives while the count is zero and the raw interrupt is clear sets the raw interrupt (bit 0 at 0x010) and reloads the count from the reload value.
- R4: A tick that arrives while the count is zero and the raw interrupt is set sets the reset status. The count then stays at zero, whatever ticks follow.
- R5: The two outputs are gated by the control bits. `wdogIrq` equals raw interrupt AND control bit 0, and the masked status at 0x014 returns the same value. `wdogRst` equals reset status AND control bit 1.
- R6: A write to 0x000 sets the reload value, loads it into the count at once and lets the count run. Any write to 0x00C clears the raw interrupt and, on a running counter, reloads the count.
- R7: The reset status stays set until the block is reset. A write to 0x00C does not restart a frozen counter.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and any other value locks it. Reading 0xC00 returns 1 when the block is locked and 0 when it is unlocked.
- R9: While the block is locked, writes to every offset other than 0xC00 have no effect.
- R10: When bit 0 at 0xF00 is set, `wdogIrq` follows bit 1 of the value written to 0xF04 and `wdogRst` follows bit 0 of it.
- R11: The identification words at 0xFD0, 0xFD4, … up to 0xFFC read, in address order: 0x04, 0x00, 0x00, 0x00, 0x24, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Reads of write-only or unmapped offsets return zero. `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB and counter clock |
| presetn | input | 1 | active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | always ready |
| pslverr | output | 1 | never errors |
| tickEn | input | 1 | watchdog tick enable |
| wdogIrq | output | 1 | interrupt request |
| wdogRst | output | 1 | reset request |

## Verification
The bench sweeps several reload values, including zero and one. For each it counts the exact number of ticks to the first and second expiry. A design that expired one tick early or late, or reloaded from the wrong value, fails there. After the freeze, the bench keeps ticking and clears the interrupt, so a counter that wrapped, restarted or dropped its reset request is caught. It also checks the case where the block is locked with a non-key value, then writes the control and reload registers and reads them back, to expose a lock that leaks writes. Finally it reads all twelve identification words and the test-mode outputs, to catch a swapped pin or a misplaced word.

// File: rtl/wdt2s_pkg.sv
package wdt2s_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 10;

  localparam logic [WORD_W-1:0] W_RELOAD = 10'h000;
  localparam logic [WORD_W-1:0] W_COUNT  = 10'h001;
  localparam logic [WORD_W-1:0] W_CTRL   = 10'h002;
  localparam logic [WORD_W-1:0] W_ACK    = 10'h003;
  localparam logic [WORD_W-1:0] W_RAW    = 10'h004;
  localparam logic [WORD_W-1:0] W_MSK    = 10'h005;
  localparam logic [WORD_W-1:0] W_KEY    = 10'h300;
  localparam logic [WORD_W-1:0] W_TEN    = 10'h3C0;
  localparam logic [WORD_W-1:0] W_TOUT   = 10'h3C1;
  localparam logic [WORD_W-1:0] W_IDLO   = 10'h3F4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic loadWr;
    logic ackWr;
  } dpStrobe_t;

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    case (idx)
      4'd0:    idByte = 8'h04;
      4'd4:    idByte = 8'h24;
      4'd5:    idByte = 8'hB8;
      4'd6:    idByte = 8'h1B;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wdt2s_dp.sv
module wdt2s_dp
  import wdt2s_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] reloadQ,
  output logic [CNT_W-1:0] countQ,
  output logic             rawIntQ,
  output logic             rstStatQ,
  output logic             haltQ
);
  localparam logic [CNT_W-1:0] RELOAD_INIT = '1;

  logic atZero;
  assign atZero = (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ  <= RELOAD_INIT;
      countQ   <= RELOAD_INIT;
      rawIntQ  <= 1'b0;
      rstStatQ <= 1'b0;
      haltQ    <= 1'b0;
    end else if (stb.loadWr) begin
      reloadQ <= wrData;
      countQ  <= wrData;
      haltQ   <= 1'b0;
    end else if (stb.ackWr) begin
      rawIntQ <= 1'b0;
      if (!haltQ) countQ <= reloadQ;
    end else if (tickEn && !haltQ) begin
      if (!atZero) begin
        countQ <= countQ - 1'b1;
      end else if (!rawIntQ) begin
        rawIntQ <= 1'b1;
        countQ  <= reloadQ;
      end else begin
        rstStatQ <= 1'b1;
        haltQ    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt2s_ctrl.sv
module wdt2s_ctrl
  import wdt2s_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  reloadQ,
  input  logic [CNT_W-1:0]  countQ,
  input  logic              rawIntQ,
  input  logic              rstStatQ,
  output dpStrobe_t         stb,
  output logic [1:0]        ctlBits,
  output logic              lockQ,
  output logic              testEn,
  output logic [1:0]        testOut,
  output logic              irqOut,
  output logic              rstOut
);
  logic [WORD_W-1:0] word;
  logic              wrAcc;
  logic              wrOk;
  logic              maskedInt;
  logic [3:0]        idIdx;
  logic              isId;

  assign word      = paddr[ADDR_W-1:2];
  assign wrAcc     = psel && penable && pwrite;
  assign wrOk      = wrAcc && (!lockQ || word == W_KEY);
  assign maskedInt = rawIntQ && ctlBits[0];
  assign isId      = (word >= W_IDLO);
  assign idIdx     = 4'(word - W_IDLO);

  assign stb.loadWr = wrOk && (word == W_RELOAD);
  assign stb.ackWr  = wrOk && (word == W_ACK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlBits <= '0;
      lockQ   <= 1'b0;
      testEn  <= 1'b0;
      testOut <= '0;
    end else if (wrOk) begin
      case (word)
        W_CTRL: ctlBits <= pwdata[1:0];
        W_KEY:  lockQ   <= (pwdata != UNLOCK_KEY);
        W_TEN:  testEn  <= pwdata[0];
        W_TOUT: testOut <= pwdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (isId) begin
        prdata = DATA_W'(idByte(idIdx));
      end else begin
        case (word)
          W_RELOAD: prdata = DATA_W'(reloadQ);
          W_COUNT:  prdata = DATA_W'(countQ);
          W_CTRL:   prdata = DATA_W'(ctlBits);
          W_RAW:    prdata = DATA_W'(rawIntQ);
          W_MSK:    prdata = DATA_W'(maskedInt);
          W_KEY:    prdata = DATA_W'(lockQ);
          W_TEN:    prdata = DATA_W'(testEn);
          default:  prdata = '0;
        endcase
      end
    end
  end

  assign irqOut = testEn ? testOut[1] : maskedInt;
  assign rstOut = testEn ? testOut[0] : (rstStatQ && ctlBits[1]);
endmodule

// File: rtl/wdt2s_top.sv
module wdt2s_top
  import wdt2s_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tickEn,
  output logic              wdogIrq,
  output logic              wdogRst
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] reloadQ;
  logic [CNT_W-1:0] countQ;
  logic             rawIntQ;
  logic             rstStatQ;
  logic             haltQ;
  logic [1:0]       ctlBits;
  logic             lockQ;
  logic             testEn;
  logic [1:0]       testOut;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt2s_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(pclk), .rstN(presetn),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .reloadQ(reloadQ), .countQ(countQ),
    .rawIntQ(rawIntQ), .rstStatQ(rstStatQ),
    .stb(stb), .ctlBits(ctlBits), .lockQ(lockQ),
    .testEn(testEn), .testOut(testOut),
    .irqOut(wdogIrq), .rstOut(wdogRst)
  );

  wdt2s_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(pclk), .rstN(presetn), .tickEn(tickEn),
    .stb(stb), .wrData(pwdata[CNT_W-1:0]),
    .reloadQ(reloadQ), .countQ(countQ),
    .rawIntQ(rawIntQ), .rstStatQ(rstStatQ), .haltQ(haltQ)
  );
endmodule

// File: rtl/wdt2s_chk.sv
module wdt2s_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              wdogIrq,
  input logic [CNT_W-1:0]  countQ,
  input logic              rawIntQ,
  input logic              rstStatQ,
  input logic              haltQ,
  input logic [1:0]        ctlBits,
  input logic              lockQ,
  input logic              testEn
);
  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  AST_RST_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    rstStatQ |=> rstStatQ); // R7

  AST_HALT_FROZEN: assert property (@(posedge pclk) disable iff (!presetn)
    haltQ && !(wrAcc && !lockQ && paddr[ADDR_W-1:2] == 10'h000) |=> $stable(countQ)); // R4

  AST_RST_NEEDS_INT: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(rstStatQ) |-> $past(rawIntQ)); // R4

  AST_LOCK_HOLDS_CTL: assert property (@(posedge pclk) disable iff (!presetn)
    wrAcc && lockQ && paddr[ADDR_W-1:2] == 10'h002 |=> $stable(ctlBits)); // R9

  AST_IRQ_GATED: assert property (@(posedge pclk) disable iff (!presetn)
    !testEn && !ctlBits[0] |-> !wdogIrq); // R5
endmodule

bind wdt2s_top wdt2s_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .wdogIrq(wdogIrq),
  .countQ(countQ), .rawIntQ(rawIntQ), .rstStatQ(rstStatQ),
  .haltQ(haltQ), .ctlBits(ctlBits), .lockQ(lockQ), .testEn(testEn)
);

// File: tb/wdt2s_top_bench.sv
module wdt2s_top_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        tickEn = 1'b0;
  logic        wdogIrq;
  logic        wdogRst;

  int nTests = 0;
  int nFail  = 0;

  always #10 pclk = ~pclk;

  wdt2s_top u_wdt2s_top (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tickEn(tickEn),
    .wdogIrq(wdogIrq), .wdogRst(wdogRst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    presetn = 1'b0;
    tickEn  = 1'b0;
    repeat (2) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge pclk);
    end
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: bench hung, actual running expected done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  idExp [12];
    idExp = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00,
              8'h0D, 8'hF0, 8'h05, 8'hB1};
    doReset();

    // R1 reset state
    rd(12'h000, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R1 control", v, 0);
    rd(12'h010, v); chk("R1 raw", v, 0);
    rd(12'hC00, v); chk("R1 lock", v, 0);
    rd(12'hF00, v); chk("R1 test enable", v, 0);
    chk("R1 irq pin", {31'd0, wdogIrq}, 0);
    chk("R1 rst pin", {31'd0, wdogRst}, 0);

    // R12 handshake and zero reads
    chk("R12 pready", {31'd0, pready}, 1);
    chk("R12 pslverr", {31'd0, pslverr}, 0);
    rd(12'h00C, v); chk("R12 ack read", v, 0);
    rd(12'hF04, v); chk("R12 test out read", v, 0);
    rd(12'h020, v); chk("R12 unmapped", v, 0);
    rd(12'h800, v); chk("R12 unmapped high", v, 0);

    // R11 identification sweep
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4 * i), v);
      chk($sformatf("R11 id word %0d", i), v, {24'd0, idExp[i]});
    end

    // R2 control width
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R2 control mask", v, 3);
    wr(12'h008, 32'hFFFF_FFFE);
    rd(12'h008, v); chk("R2 control bit1 only", v, 2);

    // R3 R4 R7 two-stage sweep over reload values
    foreach (idExp[k]) begin
      int lv;
      if (k > 4) break;
      lv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 9;
      doReset();
      wr(12'h000, lv);
      wr(12'h008, 3);
      rd(12'h004, v); chk("R6 load sets count", v, lv);
      tick(lv);
      rd(12'h004, v); chk("R3 count at zero", v, 0);
      rd(12'h010, v); chk("R3 raw before expiry", v, 0);
      tick(1);
      rd(12'h010, v); chk("R3 raw after first expiry", v, 1);
      rd(12'h004, v); chk("R3 reload after expiry", v, lv);
      chk("R5 irq pin", {31'd0, wdogIrq}, 1);
      chk("R5 rst pin early", {31'd0, wdogRst}, 0);
      tick(lv);
      chk("R4 no rst before second expiry", {31'd0, wdogRst}, 0);
      tick(1);
      chk("R4 rst after second expiry", {31'd0, wdogRst}, 1);
      tick(4);
      rd(12'h004, v); chk("R4 count frozen", v, 0);
      wr(12'h00C, 0);
      rd(12'h010, v); chk("R6 ack clears raw", v, 0);
      rd(12'h004, v); chk("R7 ack no restart", v, 0);
      tick(3);
      rd(12'h004, v); chk("R7 still frozen", v, 0);
      chk("R7 rst sticky", {31'd0, wdogRst}, 1);
      wr(12'h008, 1);
      chk("R5 rst masked", {31'd0, wdogRst}, 0);
    end

    // R5 masking of interrupt
    doReset();
    wr(12'h000, 2);
    tick(3);
    rd(12'h010, v); chk("R5 raw set unmasked", v, 1);
    rd(12'h014, v); chk("R5 masked off", v, 0);
    chk("R5 irq off", {31'd0, wdogIrq}, 0);
    wr(12'h008, 1);
    rd(12'h014, v); chk("R5 masked on", v, 1);
    chk("R5 irq on", {31'd0, wdogIrq}, 1);

    // R6 ack reloads a running counter
    doReset();
    wr(12'h000, 7);
    tick(3);
    rd(12'h004, v); chk("R3 decrement", v, 4);
    wr(12'h00C, 32'h5A5A);
    rd(12'h004, v); chk("R6 ack reloads", v, 7);
    wr(12'h000, 12);
    rd(12'h004, v); chk("R6 reload write", v, 12);

    // R8 R9 lock
    wr(12'h008, 1);
    wr(12'hC00, 32'h1ACC_E550);
    rd(12'hC00, v); chk("R8 locked", v, 1);
    wr(12'h008, 2);
    rd(12'h008, v); chk("R9 control held", v, 1);
    wr(12'h000, 3);
    rd(12'h000, v); chk("R9 reload held", v, 12);
    rd(12'h004, v); chk("R9 count held", v, 12);
    wr(12'hF00, 1);
    rd(12'hF00, v); chk("R9 test enable held", v, 0);
    wr(12'hC00, 32'h1ACC_E551);
    rd(12'hC00, v); chk("R8 unlocked", v, 0);
    wr(12'h008, 2);
    rd(12'h008, v); chk("R8 write after unlock", v, 2);

    // R10 test mode
    doReset();
    wr(12'hF00, 1);
    wr(12'hF04, 2);
    chk("R10 irq from bit1", {31'd0, wdogIrq}, 1);
    chk("R10 rst low", {31'd0, wdogRst}, 0);
    wr(12'hF04, 1);
    chk("R10 irq low", {31'd0, wdogIrq}, 0);
    chk("R10 rst from bit0", {31'd0, wdogRst}, 1);
    rd(12'hF00, v); chk("R10 enable read", v, 1);
    wr(12'hF00, 0);
    chk("R10 irq normal", {31'd0, wdogIrq}, 0);
    chk("R10 rst normal", {31'd0, wdogRst}, 0);

    finishRun();
  end
endmodule